// File: doc/BRIEF.md
# Out-of-Order Store Queue Controller

This block holds the stores of an out-of-order core in a circular queue from dispatch until memory has taken their data. Stores are allocated in program order at the tail. Each entry keeps the store's sequence number and the load-queue tail index that was current when it was allocated. Executed stores later fill in address, size and data. A commit bound from the retire stage marks older stores as allowed to write. A writeback pointer, which sits between head and tail, offers those stores one at a time and in program order to a data-cache write port.

The cache acknowledges finished writes by index, and these acknowledgements may arrive out of order. The head frees an entry only when that entry and every older one has finished. A squash from a misprediction drops the uncommitted stores younger than a given sequence number. The ring has one slot more than its usable capacity, so a full queue and an empty queue give different pointer values.

The writeback port is a two-state machine. In WB_SCAN it inspects the entry under the writeback pointer. The transition SCAN_SKIP finishes a zero-size entry in place and stays in WB_SCAN. The transition SCAN_ISSUE goes to WB_WAIT for an entry with data. In WB_WAIT the request is held. The transition WAIT_RETRY stays in WB_WAIT while the cache refuses. The transition WAIT_TAKEN returns to WB_SCAN once the cache accepts, and the pointer then moves on.

Top module: `sq_ctrl`

## Requirements
- R1: After reset the queue is empty, `full` is 0, `wr_req` is 0, `alloc_idx` is 0 and `free_cnt` equals the smaller of DEPTH and `lq_free`.
- R2: An accepted allocation writes the slot shown on `alloc_idx` and moves `alloc_idx` up by one on the next cycle. After slot DEPTH it wraps to slot 0.
- R3: When DEPTH entries are held, `full` is 1 and `free_cnt` is 0. An allocation while full is ignored and `alloc_idx` stays put.
- R4: A commit bound marks every held entry whose sequence number is at or below it as write-eligible. Younger entries are never offered to the cache.
- R5: A store-conditional (execute with `exec_cond`=1) becomes write-eligible at execute without any commit. It is still written only in program order.
- R6: Entries are offered in program order, one request at a time, and only once both executed and eligible. `wr_addr`, `wr_data`, `wr_size`, `wr_seq` and `wr_lq` carry that entry's recorded values.
- R7: While `wr_req` is 1 and `wr_accept` is 0, the same request is held unchanged on the next cycle.
- R8: An eligible entry with size 0 never raises `wr_req`. It completes in place and the pointer moves to the next entry.
- R9: A `done_valid` pulse for an entry that is not the head only records completion, and `free_cnt` does not change. When the head completes, it is freed together with every directly following completed entry, in the same cycle.
- R10: A squash frees, from the tail backwards, every entry younger than `squash_seq` that is not yet eligible. It stops at the first eligible entry, and `alloc_idx` moves back to the first freed slot.
- R11: `free_cnt` is the smaller of the store queue's free slots (DEPTH minus held entries) and the `lq_free` input.
- R12: In a cycle with `squash_valid`=1, allocation and commit requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocate a store at the tail |
| alloc_seq | input | SEQ_W | Sequence number of the new store |
| alloc_lq | input | LQ_W | Load-queue tail snapshot for the new store |
| alloc_idx | output | PTR_W | Slot the next allocation takes |
| full | output | 1 | All DEPTH entries are held |
| free_cnt | output | PTR_W | Smaller of store and load queue free counts |
| lq_free | input | LQ_W | Free entries in the load queue |
| exec_valid | input | 1 | Execute result for an entry |
| exec_idx | input | PTR_W | Entry being executed |
| exec_addr | input | ADDR_W | Store address |
| exec_size | input | SIZE_W | Access size in bytes, 0 for no access |
| exec_data | input | DATA_W | Store data |
| exec_cond | input | 1 | Entry is a store-conditional |
| commit_valid | input | 1 | Commit bound is valid |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Entries younger than this are dropped |
| wr_req | output | 1 | Cache write request |
| wr_addr | output | ADDR_W | Request address |
| wr_data | output | DATA_W | Request data |
| wr_size | output | SIZE_W | Request size |
| wr_seq | output | SEQ_W | Sequence number of the requesting entry |
| wr_lq | output | LQ_W | Load-queue snapshot of the requesting entry |
| wr_idx | output | PTR_W | Slot of the requesting entry |
| wr_accept | input | 1 | Cache takes the request this cycle |
| done_valid | input | 1 | Cache finished a write |
| done_idx | input | PTR_W | Slot whose write finished |

## Verification
The bench fills the ring and then squashes behind a store-conditional that is already eligible. A squash that ignored eligibility would pull `alloc_idx` back past that entry, and its write would be lost. It acknowledges a zero-size entry and a later write ahead of the head. A head that moved on any completion, instead of only on its own, would raise `free_cnt` too early and hand out slots that are still in flight. It holds `wr_accept` low while a request is up, which catches a pointer that advances without a handshake. It also sends a commit and a squash in the same cycle, where a design that let the commit through would start a write for a store the core has not retired.

// File: rtl/sq_pkg.sv
package sq_pkg;
    // Writeback port: scan for the next entry, or wait for the cache to take it.
    typedef enum logic [0:0] {
        WB_SCAN = 1'b0,
        WB_WAIT = 1'b1
    } wb_state_e;
endpackage

// File: rtl/sq_occupancy.sv
module sq_occupancy #(
    parameter int DEPTH = 8,
    parameter int LQ_W  = 5,
    localparam int SLOTS = DEPTH + 1,
    localparam int PTR_W = $clog2(DEPTH + 1)
) (
    input  logic [PTR_W-1:0] head,
    input  logic [PTR_W-1:0] tail,
    input  logic [LQ_W-1:0]  lq_free,
    output logic [PTR_W-1:0] occ,
    output logic             full,
    output logic [PTR_W-1:0] free_cnt
);
    int held;
    int sq_room;

    always_comb begin
        held     = (int'(tail) + SLOTS - int'(head)) % SLOTS;
        sq_room  = DEPTH - held;
        occ      = PTR_W'(held);
        full     = (held == DEPTH);
        free_cnt = (int'(lq_free) < sq_room) ? PTR_W'(lq_free) : PTR_W'(sq_room);
    end
endmodule

// File: rtl/sq_squash_walk.sv
module sq_squash_walk #(
    parameter int DEPTH = 8,
    parameter int SEQ_W = 16,
    localparam int SLOTS = DEPTH + 1,
    localparam int PTR_W = $clog2(DEPTH + 1)
) (
    input  logic             en,
    input  logic [PTR_W-1:0] tail,
    input  logic [PTR_W-1:0] occ,
    input  logic [SLOTS-1:0] vld,
    input  logic [SLOTS-1:0] elig,
    input  logic [SEQ_W-1:0] seq [SLOTS],
    input  logic [SEQ_W-1:0] bound,
    output logic [SLOTS-1:0] kill,
    output logic [PTR_W-1:0] new_tail
);
    logic walking;
    int   dropped;
    int   slot;

    // Walk from the youngest entry backwards; stop at the first survivor.
    always_comb begin
        walking = en;
        dropped = 0;
        slot    = 0;
        kill    = '0;
        for (int k = 1; k < SLOTS; k++) begin
            slot = (int'(tail) + SLOTS - k) % SLOTS;
            if (walking && (k <= int'(occ)) && vld[slot] && !elig[slot] &&
                (seq[slot] > bound)) begin
                kill[slot] = 1'b1;
                dropped++;
            end else begin
                walking = 1'b0;
            end
        end
        new_tail = PTR_W'((int'(tail) + SLOTS - dropped) % SLOTS);
    end
endmodule

// File: rtl/sq_head_skip.sv
module sq_head_skip #(
    parameter int DEPTH = 8,
    localparam int SLOTS = DEPTH + 1,
    localparam int PTR_W = $clog2(DEPTH + 1)
) (
    input  logic [PTR_W-1:0] head,
    input  logic [PTR_W-1:0] occ,
    input  logic [SLOTS-1:0] done_vec,
    output logic [SLOTS-1:0] retire,
    output logic [PTR_W-1:0] new_head
);
    logic run;
    int   steps;
    int   slot;

    // Retire the unbroken run of completed entries starting at the head.
    always_comb begin
        run    = 1'b1;
        steps  = 0;
        slot   = 0;
        retire = '0;
        for (int k = 0; k < SLOTS - 1; k++) begin
            slot = (int'(head) + k) % SLOTS;
            if (run && (k < int'(occ)) && done_vec[slot]) begin
                retire[slot] = 1'b1;
                steps++;
            end else begin
                run = 1'b0;
            end
        end
        new_head = PTR_W'((int'(head) + steps) % SLOTS);
    end
endmodule

// File: rtl/sq_ctrl.sv
module sq_ctrl
    import sq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int SEQ_W  = 16,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int SIZE_W = 4,
    parameter int LQ_W   = 5,
    localparam int SLOTS = DEPTH + 1,
    localparam int PTR_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [SEQ_W-1:0]  alloc_seq,
    input  logic [LQ_W-1:0]   alloc_lq,
    output logic [PTR_W-1:0]  alloc_idx,
    output logic              full,
    output logic [PTR_W-1:0]  free_cnt,
    input  logic [LQ_W-1:0]   lq_free,
    input  logic              exec_valid,
    input  logic [PTR_W-1:0]  exec_idx,
    input  logic [ADDR_W-1:0] exec_addr,
    input  logic [SIZE_W-1:0] exec_size,
    input  logic [DATA_W-1:0] exec_data,
    input  logic              exec_cond,
    input  logic              commit_valid,
    input  logic [SEQ_W-1:0]  commit_seq,
    input  logic              squash_valid,
    input  logic [SEQ_W-1:0]  squash_seq,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [SIZE_W-1:0] wr_size,
    output logic [SEQ_W-1:0]  wr_seq,
    output logic [LQ_W-1:0]   wr_lq,
    output logic [PTR_W-1:0]  wr_idx,
    input  logic              wr_accept,
    input  logic              done_valid,
    input  logic [PTR_W-1:0]  done_idx
);
    function automatic logic [PTR_W-1:0] ring_next(input logic [PTR_W-1:0] p);
        return (int'(p) == SLOTS - 1) ? '0 : p + 1'b1;
    endfunction

    // Per-entry flags and payload
    logic [SLOTS-1:0]  vld_q, elig_q, exe_q, cmp_q;
    logic [SLOTS-1:0]  vld_d, elig_d, exe_d, cmp_d;
    logic [SEQ_W-1:0]  seq_q  [SLOTS];
    logic [LQ_W-1:0]   lq_q   [SLOTS];
    logic [ADDR_W-1:0] addr_q [SLOTS];
    logic [DATA_W-1:0] data_q [SLOTS];
    logic [SIZE_W-1:0] size_q [SLOTS];

    // Pointers, pending-write count and port state
    logic [PTR_W-1:0] head_q, tail_q, wbp_q, pend_q;
    logic [PTR_W-1:0] head_d, tail_d, wbp_d, pend_d;
    wb_state_e        st_q, st_d;

    logic [PTR_W-1:0] occ_w;
    logic             full_w;
    logic             alloc_fire;
    logic [SLOTS-1:0] alloc_oh, exe_oh, done_oh, zero_oh;
    logic [SLOTS-1:0] mark_c, mark_sc, kill_w, ret_w, cmp_nx, cmp_new;
    logic [PTR_W-1:0] sq_tail_w;
    logic             wb_ready, zero_done, go_wait, taken;

    sq_occupancy #(.DEPTH(DEPTH), .LQ_W(LQ_W)) u_occ (
        .head     (head_q),
        .tail     (tail_q),
        .lq_free  (lq_free),
        .occ      (occ_w),
        .full     (full_w),
        .free_cnt (free_cnt)
    );

    sq_squash_walk #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_sqw (
        .en       (squash_valid),
        .tail     (tail_q),
        .occ      (occ_w),
        .vld      (vld_q),
        .elig     (elig_q),
        .seq      (seq_q),
        .bound    (squash_seq),
        .kill     (kill_w),
        .new_tail (sq_tail_w)
    );

    assign full       = full_w;
    assign alloc_idx  = tail_q;
    assign alloc_fire = alloc_valid && !full_w && !squash_valid;

    // Writeback readiness at the pointer
    always_comb begin
        wb_ready  = (wbp_q != tail_q) && vld_q[wbp_q] && elig_q[wbp_q] &&
                    exe_q[wbp_q] && !cmp_q[wbp_q] && (pend_q != '0);
        zero_done = (st_q == WB_SCAN) && wb_ready && (size_q[wbp_q] == '0);
        go_wait   = (st_q == WB_SCAN) && wb_ready && (size_q[wbp_q] != '0);
        taken     = (st_q == WB_WAIT) && wr_accept;
    end

    // Port state transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            WB_SCAN: st_d = go_wait ? WB_WAIT : WB_SCAN;
            WB_WAIT: st_d = wr_accept ? WB_SCAN : WB_WAIT;
            default: st_d = WB_SCAN;
        endcase
    end

    // Port outputs
    always_comb begin
        wr_req  = (st_q == WB_WAIT);
        wr_addr = addr_q[wbp_q];
        wr_data = data_q[wbp_q];
        wr_size = size_q[wbp_q];
        wr_seq  = seq_q[wbp_q];
        wr_lq   = lq_q[wbp_q];
        wr_idx  = wbp_q;
    end

    // One-hot decodes and eligibility marks
    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            alloc_oh[i] = alloc_fire && (int'(tail_q) == i);
            exe_oh[i]   = exec_valid && (int'(exec_idx) == i) && vld_q[i];
            done_oh[i]  = done_valid && (int'(done_idx) == i) && vld_q[i];
            zero_oh[i]  = zero_done && (int'(wbp_q) == i);
            mark_c[i]   = commit_valid && !squash_valid && vld_q[i] && !elig_q[i] &&
                          (seq_q[i] <= commit_seq);
            mark_sc[i]  = exe_oh[i] && exec_cond && !elig_q[i] && !mark_c[i] && !kill_w[i];
        end
        cmp_new = (done_oh | zero_oh) & ~cmp_q;
        cmp_nx  = cmp_q | done_oh | zero_oh;
    end

    sq_head_skip #(.DEPTH(DEPTH)) u_head (
        .head     (head_q),
        .occ      (occ_w),
        .done_vec (cmp_nx),
        .retire   (ret_w),
        .new_head (head_d)
    );

    // Next-state of flags, pointers and count
    always_comb begin
        vld_d  = (vld_q & ~kill_w & ~ret_w) | alloc_oh;
        elig_d = (elig_q | mark_c | mark_sc) & ~kill_w & ~ret_w & ~alloc_oh;
        exe_d  = (exe_q | exe_oh) & ~kill_w & ~ret_w & ~alloc_oh;
        cmp_d  = cmp_nx & ~kill_w & ~ret_w & ~alloc_oh;
        tail_d = squash_valid ? sq_tail_w : (alloc_fire ? ring_next(tail_q) : tail_q);
        wbp_d  = (zero_done || taken) ? ring_next(wbp_q) : wbp_q;
        pend_d = PTR_W'(int'(pend_q) + $countones(mark_c | mark_sc) - $countones(cmp_new));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= WB_SCAN;
            vld_q  <= '0;
            elig_q <= '0;
            exe_q  <= '0;
            cmp_q  <= '0;
            head_q <= '0;
            tail_q <= '0;
            wbp_q  <= '0;
            pend_q <= '0;
        end else begin
            st_q   <= st_d;
            vld_q  <= vld_d;
            elig_q <= elig_d;
            exe_q  <= exe_d;
            cmp_q  <= cmp_d;
            head_q <= head_d;
            tail_q <= tail_d;
            wbp_q  <= wbp_d;
            pend_q <= pend_d;
        end
    end

    // Payload storage, no reset needed
    always_ff @(posedge clk) begin
        for (int i = 0; i < SLOTS; i++) begin
            if (alloc_oh[i]) begin
                seq_q[i] <= alloc_seq;
                lq_q[i]  <= alloc_lq;
            end
            if (exe_oh[i]) begin
                addr_q[i] <= exec_addr;
                data_q[i] <= exec_data;
                size_q[i] <= exec_size;
            end
        end
    end
endmodule

// File: rtl/sq_checker.sv
module sq_checker #(
    parameter int DEPTH  = 8,
    parameter int PTR_W  = 4,
    parameter int LQ_W   = 5,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int SIZE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              full,
    input logic              alloc_valid,
    input logic              squash_valid,
    input logic [PTR_W-1:0]  alloc_idx,
    input logic              wr_req,
    input logic              wr_accept,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [SIZE_W-1:0] wr_size,
    input logic [PTR_W-1:0]  wr_idx,
    input logic [PTR_W-1:0]  free_cnt,
    input logic [LQ_W-1:0]   lq_free,
    input logic [PTR_W-1:0]  occ
);
    assert_full_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        full && alloc_valid && !squash_valid |=> $stable(alloc_idx));

    assert_occ_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occ) <= DEPTH);

    assert_retry_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req && !wr_accept |=> wr_req && $stable(wr_idx) && $stable(wr_addr) &&
                                 $stable(wr_data) && $stable(wr_size));

    assert_zero_no_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> (wr_size != '0));

    assert_free_min_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(free_cnt) <= int'(lq_free)) && (int'(free_cnt) <= DEPTH - int'(occ)));
endmodule

bind sq_ctrl sq_checker #(
    .DEPTH(DEPTH), .PTR_W(PTR_W), .LQ_W(LQ_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .full         (full),
    .alloc_valid  (alloc_valid),
    .squash_valid (squash_valid),
    .alloc_idx    (alloc_idx),
    .wr_req       (wr_req),
    .wr_accept    (wr_accept),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .wr_size      (wr_size),
    .wr_idx       (wr_idx),
    .free_cnt     (free_cnt),
    .lq_free      (lq_free),
    .occ          (occ_w)
);

// File: tb/sim_sq_ctrl.sv
module sim_sq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 1'b0;
    logic [15:0] alloc_seq = '0;
    logic [4:0]  alloc_lq = '0;
    logic [3:0]  alloc_idx;
    logic        full;
    logic [3:0]  free_cnt;
    logic [4:0]  lq_free = 5'd15;
    logic        exec_valid = 1'b0;
    logic [3:0]  exec_idx = '0;
    logic [31:0] exec_addr = '0;
    logic [3:0]  exec_size = '0;
    logic [63:0] exec_data = '0;
    logic        exec_cond = 1'b0;
    logic        commit_valid = 1'b0;
    logic [15:0] commit_seq = '0;
    logic        squash_valid = 1'b0;
    logic [15:0] squash_seq = '0;
    logic        wr_req;
    logic [31:0] wr_addr;
    logic [63:0] wr_data;
    logic [3:0]  wr_size;
    logic [15:0] wr_seq;
    logic [4:0]  wr_lq;
    logic [3:0]  wr_idx;
    logic        wr_accept = 1'b0;
    logic        done_valid = 1'b0;
    logic [3:0]  done_idx = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    sq_ctrl u0 (.*);

    // Table rows: {op, arg, expected free_cnt, expected alloc_idx}
    // op 1 = allocate (arg = seq), 2 = commit (arg = bound), 3 = squash (arg = bound)
    localparam int NROW = 9;
    localparam logic [35:0] TBL [NROW] = '{
        {4'd1, 16'd10, 8'd7, 8'd1},
        {4'd1, 16'd11, 8'd6, 8'd2},
        {4'd1, 16'd12, 8'd5, 8'd3},
        {4'd1, 16'd13, 8'd4, 8'd4},
        {4'd3, 16'd11, 8'd6, 8'd2},
        {4'd1, 16'd20, 8'd5, 8'd3},
        {4'd2, 16'd10, 8'd5, 8'd3},
        {4'd3, 16'd5,  8'd7, 8'd1},
        {4'd1, 16'd30, 8'd6, 8'd2}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_alloc(input int seq, input int lq);
        alloc_valid = 1'b1;
        alloc_seq   = 16'(seq);
        alloc_lq    = 5'(lq);
        tick();
        alloc_valid = 1'b0;
    endtask

    task automatic do_exec(input int idx, input int addr, input int size, input int data, input bit cond);
        exec_valid = 1'b1;
        exec_idx   = 4'(idx);
        exec_addr  = 32'(addr);
        exec_size  = 4'(size);
        exec_data  = 64'(data);
        exec_cond  = cond;
        tick();
        exec_valid = 1'b0;
        exec_cond  = 1'b0;
    endtask

    task automatic do_commit(input int seq);
        commit_valid = 1'b1;
        commit_seq   = 16'(seq);
        tick();
        commit_valid = 1'b0;
    endtask

    task automatic do_squash(input int seq);
        squash_valid = 1'b1;
        squash_seq   = 16'(seq);
        tick();
        squash_valid = 1'b0;
    endtask

    task automatic do_accept();
        wr_accept = 1'b1;
        tick();
        wr_accept = 1'b0;
    endtask

    task automatic do_done(input int idx);
        done_valid = 1'b1;
        done_idx   = 4'(idx);
        tick();
        done_valid = 1'b0;
    endtask

    task automatic wait_req(input string req);
        for (int i = 0; i < 10; i++) begin
            if (!wr_req) tick();
        end
        chk(req, wr_req, 1);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
        tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog (all requirements) actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state
        chk("R1 full", full, 0);
        chk("R1 wr_req", wr_req, 0);
        chk("R1 alloc_idx", alloc_idx, 0);
        chk("R1 free_cnt", free_cnt, 8);

        // Table walk: allocation, squash and commit (R2 R10 R4)
        for (int r = 0; r < NROW; r++) begin
            case (TBL[r][35:32])
                4'd1: do_alloc(int'(TBL[r][31:16]), 0);
                4'd2: do_commit(int'(TBL[r][31:16]));
                default: do_squash(int'(TBL[r][31:16]));
            endcase
            chk("R2/R10 table free_cnt", free_cnt, longint'(TBL[r][15:8]));
            chk("R2/R10 table alloc_idx", alloc_idx, longint'(TBL[r][7:0]));
        end

        do_reset();
        // R11: load queue limits the free count
        lq_free = 5'd3;
        #1;
        chk("R11 free_cnt with lq_free=3", free_cnt, 3);
        lq_free = 5'd15;
        #1;
        chk("R11 free_cnt with lq_free=15", free_cnt, 8);

        // R3: fill the ring
        for (int i = 0; i < 8; i++) do_alloc(i + 1, 16 + i);
        chk("R3 full", full, 1);
        chk("R3 free_cnt", free_cnt, 0);
        chk("R3 alloc_idx", alloc_idx, 8);
        do_alloc(99, 0);
        chk("R3 alloc while full ignored", alloc_idx, 8);

        do_exec(0, 'h100, 4, 'hA0, 1'b0);
        do_exec(1, 'h180, 0, 'h00, 1'b0);
        do_exec(2, 'h200, 2, 'hB0, 1'b0);
        do_exec(3, 'h300, 4, 'hC0, 1'b1);

        // R10 / R5: squash stops at the store-conditional in slot 3
        do_squash(2);
        chk("R10 alloc_idx after squash", alloc_idx, 4);
        chk("R10 free_cnt after squash", free_cnt, 4);
        tick();
        chk("R4 no request before commit", wr_req, 0);

        // R6 / R7: commit bound 2, request for slot 0 held while refused
        do_commit(2);
        wait_req("R6 request for slot 0");
        chk("R6 wr_addr", wr_addr, 'h100);
        chk("R6 wr_seq", wr_seq, 1);
        chk("R6 wr_lq", wr_lq, 16);
        chk("R6 wr_idx", wr_idx, 0);
        tick();
        tick();
        chk("R7 held request", wr_req, 1);
        chk("R7 held address", wr_addr, 'h100);
        do_accept();

        // R8: zero-size slot 1 finishes without a request; slot 2 not committed (R4)
        tick();
        tick();
        tick();
        chk("R8/R4 no request", wr_req, 0);
        chk("R9 free_cnt before head completes", free_cnt, 4);
        do_done(0);
        chk("R9 head skips slots 0 and 1", free_cnt, 6);

        // R5: slot 2 then the store-conditional in slot 3, in order
        do_commit(3);
        wait_req("R6 request for slot 2");
        chk("R6 wr_idx slot 2", wr_idx, 2);
        chk("R6 wr_size slot 2", wr_size, 2);
        chk("R6 wr_data slot 2", wr_data, 'hB0);
        do_accept();
        wait_req("R5 request for store-conditional");
        chk("R5 wr_addr slot 3", wr_addr, 'h300);
        chk("R5 wr_seq slot 3", wr_seq, 4);
        do_accept();

        // R9: out-of-order completion
        do_done(3);
        chk("R9 non-head completion keeps free_cnt", free_cnt, 6);
        do_done(2);
        chk("R9 head frees two", free_cnt, 8);

        // R12: allocation and commit ignored in a squash cycle
        alloc_valid = 1'b1;
        alloc_seq   = 16'd50;
        do_squash(0);
        alloc_valid = 1'b0;
        chk("R12 alloc ignored during squash", alloc_idx, 4);
        chk("R12 free_cnt", free_cnt, 8);
        do_alloc(60, 7);
        do_exec(4, 'h400, 4, 'hD0, 1'b0);
        commit_valid = 1'b1;
        commit_seq   = 16'd60;
        do_squash(100);
        commit_valid = 1'b0;
        tick();
        tick();
        tick();
        chk("R12 commit ignored during squash", wr_req, 0);
        chk("R12 entry kept by older squash", alloc_idx, 5);
        do_commit(60);
        wait_req("R4 request after real commit");
        chk("R6 wr_seq slot 4", wr_seq, 60);
        chk("R6 wr_lq slot 4", wr_lq, 7);
        do_accept();
        do_done(4);
        chk("R9 free after slot 4", free_cnt, 8);

        // R2: tail wraps from slot 8 to slot 0
        for (int i = 0; i < 4; i++) do_alloc(70 + i, 0);
        chk("R2 alloc_idx wraps", alloc_idx, 0);
        chk("R2 free_cnt after wrap", free_cnt, 4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule